// File: doc/BRIEF.md
# Internal/External I/O Cycle Controller

This block turns single I/O requests from a processor core into bus cycles. Each request carries a 16-bit I/O address. If the upper byte of that address is zero, the request targets a small on-chip register bank and is served from that bank. A duplicate "shadow" cycle still appears on the external bus for every such request. The shadow cycle always uses the fixed internal length. It ignores the external wait input and the programmed wait-state count. When the shadow cycle is a read, the data returned on the external bus is dropped.

Every other address runs a true external cycle. That cycle is stretched by a programmable number of wait states. It is then stretched further for as long as the external wait input is held low. The wait-state count sits in internal register 0x0000, so it is programmed with an ordinary internal write, and that write is mirrored on the bus like any other.

The core handshake is simple. The core raises a request with address, direction and write data, and it receives a one-clock acknowledge together with the read data when the cycle ends.

Top module: `iocyc_ctrl`

## Requirements
- R1: An access is internal exactly when address bits 15..8 are all zero. Of that window, only offsets 0x00..0x07 hold storage. Other offsets in the window read as zero, and writes to them change nothing.
- R2: From T1 through T3, the external address equals the 16-bit request address zero-extended to 19 bits, so bits 18..16 are zero. It is zero while idle.
- R3: The active-low enable and the active-low read strobe (for reads) or write strobe (for writes) are high in T1, low from T2 to the end of the cycle, and high when idle. The other strobe stays high throughout.
- R4: On writes, the data-enable output is high from T1 through the last state and carries the write data. On reads and when idle, the data-enable output is low.
- R5: Internal accesses always take exactly 3 clocks from acceptance to acknowledge, whatever the programmed count N and the wait input.
- R6: External accesses take 3+N clocks plus one clock for each consecutive low sample of the wait input. The wait input is first sampled at the end of the last programmed wait state (or at the end of T2 when N is 0), and then at the end of each added state.
- R7: An internal read returns the register value and ignores the external data. An internal write updates the register and drives the same address and data on the external bus.
- R8: An external read returns the value on the external data input during the acknowledge clock.
- R9: The acknowledge is high for exactly one clock, in T3. Read data is valid with the acknowledge and is zero otherwise. The controller is idle in the following clock.
- R10: Bits 1..0 of internal register 0x0000 give N. N applies to every external cycle that starts after the write has been acknowledged.
- R11: After reset, the controller is idle, all strobes are high, data-enable and acknowledge are low, and all internal registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Core request, accepted when the controller is idle |
| addr | input | 16 | Core I/O address |
| we | input | 1 | 1 = write, 0 = read |
| wdata | input | 8 | Core write data |
| ack | output | 1 | One-clock cycle completion |
| rdata | output | 8 | Read data, valid with ack |
| io_addr | output | 19 | External address |
| io_en_n | output | 1 | Active-low I/O enable |
| io_rd_n | output | 1 | Active-low read strobe |
| io_wr_n | output | 1 | Active-low write strobe |
| io_dout | output | 8 | External write data |
| io_doe | output | 1 | External data drive enable |
| io_din | input | 8 | External read data |
| io_wait_n | input | 1 | Active-low wait request |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 256-byte internal window holding eight registers, and a 2-bit wait-state count. With these values, every programmed count from 0 to 3 can be swept. For each count, the wait input is held low for 0 to 5 clocks, on internal and external reads and writes alike. This covers every relation between the wait release and the last programmed state. It also shows that shadow cycles never stretch. The window boundary addresses 0x0007, 0x0008, 0x00FF and 0x0100 are exercised as well.

// File: rtl/iocyc_pkg.sv
package iocyc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4
  } cyc_state_e;

  // Decide whether the cycle stays in (or enters) a wait state at the end of
  // T2 or of a wait state. Shadow cycles never stretch.
  function automatic logic hold_in_wait(input logic internal,
                                        input logic prog_left,
                                        input logic wait_n);
    return !internal && (prog_left || !wait_n);
  endfunction

endpackage

// File: rtl/iocyc_decode.sv
module iocyc_decode #(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 8,
  parameter int NREG   = 8,
  parameter int IDX_W  = $clog2(NREG)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic              idx_ok
);

  localparam logic [WIN_W:0] NREG_LIM = (WIN_W+1)'(NREG);

  always_comb begin
    hit    = (addr[ADDR_W-1:WIN_W] == '0);
    idx    = addr[IDX_W-1:0];
    idx_ok = hit && ({1'b0, addr[WIN_W-1:0]} < NREG_LIM);
  end

endmodule

// File: rtl/iocyc_regfile.sv
module iocyc_regfile #(
  parameter int DATA_W = 8,
  parameter int NREG   = 8,
  parameter int IDX_W  = $clog2(NREG),
  parameter int WS_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rdata,
  output logic [WS_W-1:0]   ws_cfg
);

  logic [NREG-1:0][DATA_W-1:0] regs;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        regs[g] <= wdata;
    end
  end

  assign rdata  = regs[rd_idx];
  assign ws_cfg = regs[0][WS_W-1:0];

  assert_ws_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == '0) |=> (ws_cfg == $past(wdata[WS_W-1:0])));

endmodule

// File: rtl/iocyc_seq.sv
module iocyc_seq
  import iocyc_pkg::*;
#(
  parameter int WS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            internal,
  input  logic [WS_W-1:0] ws_cfg,
  input  logic            wait_n,
  output cyc_state_e      state,
  output logic            busy,
  output logic            strobe_on,
  output logic            done
);

  cyc_state_e      nxt;
  logic [WS_W-1:0] wcnt, wcnt_nxt;
  logic            prog_left;
  logic            stretch;

  assign prog_left = (wcnt != '0);
  assign stretch   = hold_in_wait(internal, prog_left, wait_n);

  always_comb begin
    nxt      = state;
    wcnt_nxt = wcnt;
    unique case (state)
      ST_IDLE: if (start) nxt = ST_T1;
      ST_T1: begin
        nxt      = ST_T2;
        wcnt_nxt = internal ? '0 : ws_cfg;
      end
      ST_T2, ST_TW: begin
        nxt = stretch ? ST_TW : ST_T3;
        if (stretch && prog_left) wcnt_nxt = wcnt - 1'b1;
      end
      ST_T3:   nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      wcnt  <= '0;
    end else begin
      state <= nxt;
      wcnt  <= wcnt_nxt;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign strobe_on = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
  assign done      = (state == ST_T3);

  assert_int_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T2 && internal) |=> (state == ST_T3));

  assert_no_wait_internal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && internal) |-> (state != ST_TW));

  assert_wait_extends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_T2 || state == ST_TW) && !internal && !prog_left && !wait_n)
      |=> (state == ST_TW));

  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T3) |=> (state == ST_IDLE));

endmodule

// File: rtl/iocyc_ctrl.sv
module iocyc_ctrl
  import iocyc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int EXT_W  = 19,
  parameter int DATA_W = 8,
  parameter int WIN_W  = 8,
  parameter int NREG   = 8,
  parameter int WS_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [EXT_W-1:0]  io_addr,
  output logic              io_en_n,
  output logic              io_rd_n,
  output logic              io_wr_n,
  output logic [DATA_W-1:0] io_dout,
  output logic              io_doe,
  input  logic [DATA_W-1:0] io_din,
  input  logic              io_wait_n
);

  localparam int IDX_W = $clog2(NREG);

  cyc_state_e        state;
  logic              busy, strobe_on, done, start;
  logic              dec_hit, dec_ok;
  logic [IDX_W-1:0]  dec_idx;
  logic [ADDR_W-1:0] c_addr;
  logic              c_we, c_int, c_ok;
  logic [DATA_W-1:0] c_wdata;
  logic [IDX_W-1:0]  c_idx;
  logic [DATA_W-1:0] reg_rd;
  logic [WS_W-1:0]   ws_cfg;
  logic              reg_wr;

  assign start = (state == ST_IDLE) && req;

  iocyc_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .NREG(NREG), .IDX_W(IDX_W)) u_dec (
    .addr(addr), .hit(dec_hit), .idx(dec_idx), .idx_ok(dec_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_addr  <= '0;
      c_we    <= 1'b0;
      c_wdata <= '0;
      c_int   <= 1'b0;
      c_ok    <= 1'b0;
      c_idx   <= '0;
    end else if (start) begin
      c_addr  <= addr;
      c_we    <= we;
      c_wdata <= wdata;
      c_int   <= dec_hit;
      c_ok    <= dec_ok;
      c_idx   <= dec_idx;
    end
  end

  iocyc_seq #(.WS_W(WS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .internal(c_int),
    .ws_cfg(ws_cfg), .wait_n(io_wait_n), .state(state), .busy(busy),
    .strobe_on(strobe_on), .done(done)
  );

  assign reg_wr = done && c_we && c_ok;

  iocyc_regfile #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W), .WS_W(WS_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_idx(c_idx), .wdata(c_wdata),
    .rd_idx(c_idx), .rdata(reg_rd), .ws_cfg(ws_cfg)
  );

  always_comb begin
    io_addr = busy ? EXT_W'(c_addr) : '0;
    io_en_n = !strobe_on;
    io_rd_n = !(strobe_on && !c_we);
    io_wr_n = !(strobe_on && c_we);
    io_doe  = busy && c_we;
    io_dout = io_doe ? c_wdata : '0;
    ack     = done;
    rdata   = '0;
    if (done && !c_we)
      rdata = c_int ? (c_ok ? reg_rd : '0) : io_din;
  end

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!io_rd_n && !io_wr_n));

  assert_en_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd_n || !io_wr_n) |-> !io_en_n);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |-> $stable(io_addr));

  assert_drive_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    io_doe |-> io_rd_n);

endmodule

// File: tb/tb_iocyc_ctrl.sv
module tb_iocyc_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] addr = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic        ack;
  logic [7:0]  rdata;
  logic [18:0] io_addr;
  logic        io_en_n, io_rd_n, io_wr_n, io_doe;
  logic [7:0]  io_dout;
  logic [7:0]  io_din = '0;
  logic        io_wait_n = 1'b1;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [8];

  always #4 clk = ~clk;

  iocyc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .we(we), .wdata(wdata),
    .ack(ack), .rdata(rdata), .io_addr(io_addr), .io_en_n(io_en_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_dout(io_dout), .io_doe(io_doe),
    .io_din(io_din), .io_wait_n(io_wait_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ext_val(input logic [15:0] a);
    return 8'h5A ^ a[7:0] ^ a[15:8];
  endfunction

  // R5/R6 length model: internal fixed, external 3 + N + late wait release.
  function automatic int cycle_len(input bit intl, input int n, input int r);
    int extra;
    extra = r - 2 - n;
    if (extra < 0) extra = 0;
    return intl ? 3 : 3 + n + extra;
  endfunction

  task automatic run_cycle(input logic [15:0] a, input logic w, input logic [7:0] d,
                           input int r);
    bit         intl;
    int         n, exp_len, cnt;
    bit         got;
    logic [7:0] exp_rd;
    logic [2:0] exp_str;
    intl    = (a[15:8] == 8'h00);
    n       = int'(model[0][1:0]);
    exp_len = cycle_len(intl, n, r);
    exp_rd  = intl ? ((a[7:0] < 8'd8) ? model[a[2:0]] : 8'h00) : ext_val(a);
    @(negedge clk);
    req = 1'b1; addr = a; we = w; wdata = d;
    io_din = ext_val(a);
    io_wait_n = (r == 0);
    cnt = 0; got = 0;
    while (!got && cnt < 40) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      req = 1'b0;
      if (cnt == r) io_wait_n = 1'b1;
      // R2 address
      chk(io_addr == {3'b000, a}, "R2 io_addr", 32'(io_addr), 32'({3'b000, a}));
      // R3 strobes: {en_n, rd_n, wr_n}
      exp_str = (cnt == 1) ? 3'b111 : (w ? 3'b010 : 3'b001);
      chk({io_en_n, io_rd_n, io_wr_n} == exp_str, "R3 strobes",
          32'({io_en_n, io_rd_n, io_wr_n}), 32'(exp_str));
      // R4 data drive
      chk(io_doe == w, "R4 io_doe", 32'(io_doe), 32'(w));
      if (w) chk(io_dout == d, "R4 io_dout", 32'(io_dout), 32'(d));
      if (ack) begin
        got = 1;
        if (!w) chk(rdata == exp_rd, intl ? "R7 internal rdata" : "R8 external rdata",
                    32'(rdata), 32'(exp_rd));
      end else begin
        chk(rdata == 8'h00, "R9 rdata idle", 32'(rdata), 32'h0);
      end
    end
    chk(cnt == exp_len, intl ? "R5 internal length" : "R6 external length",
        32'(cnt), 32'(exp_len));
    if (w && intl && a[7:0] < 8'd8) model[a[2:0]] = d;
    io_wait_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk({ack, io_en_n, io_rd_n, io_wr_n, io_doe} == 5'b01110, "R9 one-clock ack",
        32'({ack, io_en_n, io_rd_n, io_wr_n, io_doe}), 32'h0e);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({ack, io_en_n, io_rd_n, io_wr_n, io_doe} == 5'b01110, "R11 reset outputs",
        32'({ack, io_en_n, io_rd_n, io_wr_n, io_doe}), 32'h0e);
    chk(io_addr == '0, "R11 reset address", 32'(io_addr), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(io_en_n && !ack, "R11 idle after reset", 32'({io_en_n, ack}), 32'h2);

    // R11/R7 registers read zero; wait held low has no effect (R5)
    for (int i = 0; i < 8; i++) run_cycle(16'(i), 1'b0, 8'h00, 3);

    // R7 internal writes and readbacks
    for (int i = 1; i < 8; i++) run_cycle(16'(i), 1'b1, 8'(8'h13 * i + 1), 2);
    for (int i = 1; i < 8; i++) run_cycle(16'(i), 1'b0, 8'h00, 0);

    // R1 window edges: storage-free offsets and first external address
    run_cycle(16'h0008, 1'b1, 8'hEE, 4);
    run_cycle(16'h0008, 1'b0, 8'h00, 0);
    run_cycle(16'h00FF, 1'b1, 8'hDD, 0);
    run_cycle(16'h00FF, 1'b0, 8'h00, 5);
    run_cycle(16'h0100, 1'b0, 8'h00, 0);
    run_cycle(16'h0107, 1'b1, 8'h77, 0);
    run_cycle(16'h0007, 1'b0, 8'h00, 0);

    // R10/R6 sweep of programmed count and wait release
    for (int n = 0; n < 4; n++) begin
      run_cycle(16'h0000, 1'b1, 8'(8'hA8 | n), 4);
      run_cycle(16'h0000, 1'b0, 8'h00, 0);
      for (int r = 0; r < 6; r++) begin
        run_cycle(16'(16'h1200 + 16'(r)), 1'b0, 8'h00, r);
        run_cycle(16'(16'hFF00 + 16'(r)), 1'b1, 8'(8'h40 + r), r);
        run_cycle(16'h0003, 1'b0, 8'h00, r);
        run_cycle(16'h0005, 1'b1, 8'(8'h90 + r), r);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule